// File: doc/BRIEF.md
# Dual-Layout Multicart Bank Mapper

This block is the banking logic of a multi-game cartridge that sits on an 8-bit console CPU bus. It keeps two 8-bit registers, called outer and inner here. Both are loaded by CPU writes, which it decodes from the address and a single-cycle write strobe. From these registers it produces three outputs at all times. The first is a 32 KiB program bank number. The second is an 8 KiB character bank number. The third is a nametable mirroring select.

Outer bit 5 picks one of two personalities.

- **Outer bit 5 clear (low-window mode).** The inner register is written in the 0x4100–0x7FFF window.
- **Outer bit 5 set (latch mode).** The low-window inner register is locked. Writes anywhere in 0x8000–0xFFFF load it instead, after their data is rearranged into the low-window field order.

Outer bit 6 selects where one bit of the program bank and one bit of the character bank come from. That source is either the inner register or outer bit 0. A strap input switches the low window to an older, simpler decode that has no lock.

The bank and mirror outputs are combinational from the registers. A write is taken on the rising clock edge at which `wr_en` is high. Every pin is a plain control or status signal. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `dualmode_mapper`

## Requirements
- R1: An active-low reset clears both registers, so that `prg_bank`, `chr_bank` and `mirror_h` all read zero.
- R2: With `proto_mode`=0, a write in 0x4100–0x7FFF with address bit 8 = 1 and address bit 7 = 1 loads the outer register with `cpu_data`. This happens regardless of mode.
- R3: With `proto_mode`=0, a write in 0x4100–0x7FFF with bit 8 = 1 and bit 7 = 0 loads the inner register only while outer bit 5 is 0. A write there with bit 8 = 0 changes nothing.
- R4: A write in 0x8000–0xFFFF loads the inner register only while outer bit 5 is 1. The loaded value is: inner bit 3 = data bit 0, inner bits 2:0 = data bits 6:4, and inner bits 7:4 = 0. While outer bit 5 is 0, such a write changes nothing.
- R5: With `proto_mode`=1, a write in 0x4100–0x7FFF with address bit 9 = 1 loads the outer register. Otherwise, if bit 8 = 1, it loads the inner register whatever the state of outer bit 5. Writes with both bits clear change nothing.
- R6: `prg_bank`[5:1] = outer[5:1]. `prg_bank`[0] = inner[3] when outer bit 6 is 1, and outer[0] otherwise.
- R7: `chr_bank`[1:0] = inner[1:0] and `chr_bank`[7:3] = outer[5:1]. `chr_bank`[2] = inner[2] when outer bit 6 is 1, and outer[0] otherwise.
- R8: `mirror_h` equals outer bit 7, where 1 means horizontal mirroring and 0 means vertical.
- R9: Writes to addresses below 0x4100, and bus cycles with `wr_en` low, never change either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; writes are captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address of the bus cycle |
| cpu_data | input | 8 | CPU write data |
| wr_en | input | 1 | Single-cycle write strobe |
| proto_mode | input | 1 | Strap: 1 selects the prototype low-window decode |
| prg_bank | output | 6 | 32 KiB program bank number |
| chr_bank | output | 8 | 8 KiB character bank number |
| mirror_h | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
The bench writes all 256 outer values. Each outer write is followed by an inner write in the low window and a write in the latch window. This covers both settings of the lock bit and the layout bit with data that differs bit by bit, so it separates a wrong bank-bit source, a swapped translation field, and a lock applied in the wrong window.

An address sweep covers all 256 address pages at four in-page offsets, first in the normal decode and then with the prototype strap. It tells apart the decodes on bits 9, 8 and 7, the lower window boundary at 0x4100, and the unlocked prototype inner write.

Idle bus cycles carrying register-like data, and a reset taken from a non-zero state, complete the coverage.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  localparam int unsigned ADDR_W     = 16;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned PRG_W      = 6;
  localparam int unsigned CHR_W      = 8;
  localparam int unsigned LOCK_BIT   = 5;
  localparam int unsigned LAYOUT_BIT = 6;
  localparam int unsigned MIRROR_BIT = 7;
  localparam int unsigned SHARED_W   = PRG_W - 1;
  localparam logic [ADDR_W-1:0] LOW_FIRST = 16'h4100;
  localparam logic [ADDR_W-1:0] LOW_LAST  = 16'h7FFF;

  typedef struct packed {
    logic [DATA_W-1:0] outer;
    logic [DATA_W-1:0] inner;
  } bank_regs_t;
endpackage

// File: rtl/mmap_wr_decode.sv
module mmap_wr_decode
  import mmap_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              wr_en,
  input  logic              proto_mode,
  input  logic              lock,
  output logic              ld_outer,
  output logic              ld_inner,
  output logic [DATA_W-1:0] inner_val
);
  logic in_low, in_high, low_outer, low_inner;
  logic [DATA_W-1:0] latch_val;

  always_comb begin
    in_low  = (addr >= LOW_FIRST) && (addr <= LOW_LAST);
    in_high = addr[ADDR_W-1];
    if (proto_mode) begin
      low_outer = addr[9];
      low_inner = !addr[9] && addr[8];
    end else begin
      low_outer = addr[8] && addr[7];
      low_inner = addr[8] && !addr[7] && !lock;
    end
    latch_val = {{(DATA_W-4){1'b0}}, data[0], data[6:4]};
    ld_outer  = wr_en && in_low && low_outer;
    ld_inner  = wr_en && ((in_low && low_inner) || (in_high && lock));
    inner_val = in_high ? latch_val : data;
  end
endmodule

// File: rtl/mmap_bank_regs.sv
module mmap_bank_regs
  import mmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_outer,
  input  logic              ld_inner,
  input  logic [DATA_W-1:0] outer_d,
  input  logic [DATA_W-1:0] inner_d,
  output bank_regs_t        regs_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else begin
      if (ld_outer) regs_q.outer <= outer_d;
      if (ld_inner) regs_q.inner <= inner_d;
    end
  end

  // a load strobe in one window never coincides with one in the other
  assert_single_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_outer && ld_inner));
endmodule

// File: rtl/mmap_bank_out.sv
module mmap_bank_out
  import mmap_pkg::*;
(
  input  bank_regs_t        regs,
  output logic [PRG_W-1:0]  prg_bank,
  output logic [CHR_W-1:0]  chr_bank,
  output logic              mirror_h
);
  logic alt_src;
  logic [SHARED_W-1:0] shared;

  always_comb begin
    alt_src  = regs.outer[LAYOUT_BIT];
    shared   = regs.outer[SHARED_W:1];
    prg_bank = {shared, alt_src ? regs.inner[3] : regs.outer[0]};
    chr_bank = {shared, alt_src ? regs.inner[2] : regs.outer[0], regs.inner[1:0]};
    mirror_h = regs.outer[MIRROR_BIT];
  end
endmodule

// File: rtl/dualmode_mapper.sv
module dualmode_mapper
  import mmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              wr_en,
  input  logic              proto_mode,
  output logic [PRG_W-1:0]  prg_bank,
  output logic [CHR_W-1:0]  chr_bank,
  output logic              mirror_h
);
  bank_regs_t        regs_q;
  logic              ld_outer, ld_inner;
  logic [DATA_W-1:0] inner_val;

  mmap_wr_decode u_decode (
    .addr       (cpu_addr),
    .data       (cpu_data),
    .wr_en      (wr_en),
    .proto_mode (proto_mode),
    .lock       (regs_q.outer[LOCK_BIT]),
    .ld_outer   (ld_outer),
    .ld_inner   (ld_inner),
    .inner_val  (inner_val)
  );

  mmap_bank_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_outer (ld_outer),
    .ld_inner (ld_inner),
    .outer_d  (cpu_data),
    .inner_d  (inner_val),
    .regs_q   (regs_q)
  );

  mmap_bank_out u_out (
    .regs     (regs_q),
    .prg_bank (prg_bank),
    .chr_bank (chr_bank),
    .mirror_h (mirror_h)
  );

  logic low_win;
  assign low_win = (cpu_addr >= LOW_FIRST) && (cpu_addr <= LOW_LAST);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(regs_q.outer) && $stable(regs_q.inner)));

  assert_below_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cpu_addr < LOW_FIRST) |=> ($stable(regs_q.outer) && $stable(regs_q.inner)));

  assert_outer_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !proto_mode && low_win && cpu_addr[8] && cpu_addr[7])
      |=> (regs_q.outer == $past(cpu_data)));

  assert_inner_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !proto_mode && low_win && cpu_addr[8] && !cpu_addr[7] && regs_q.outer[LOCK_BIT])
      |=> $stable(regs_q.inner));

  assert_latch_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cpu_addr[ADDR_W-1] && !regs_q.outer[LOCK_BIT])
      |=> ($stable(regs_q.inner) && $stable(regs_q.outer)));

  assert_latch_upper_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cpu_addr[ADDR_W-1] && regs_q.outer[LOCK_BIT])
      |=> (regs_q.inner[DATA_W-1:4] == '0));

  assert_proto_inner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && proto_mode && low_win && !cpu_addr[9] && cpu_addr[8])
      |=> (regs_q.inner == $past(cpu_data)));

  assert_shared_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prg_bank[PRG_W-1:1] == chr_bank[CHR_W-1:3]);
endmodule

// File: tb/dualmode_mapper_tb.sv
module dualmode_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        wr_en = 1'b0;
  logic        proto_mode = 1'b0;
  logic [5:0]  prg_bank;
  logic [7:0]  chr_bank;
  logic        mirror_h;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] mo = '0;
  logic [7:0] mi = '0;

  always #5 clk = ~clk;

  dualmode_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .wr_en(wr_en), .proto_mode(proto_mode),
    .prg_bank(prg_bank), .chr_bank(chr_bank), .mirror_h(mirror_h)
  );

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [5:0] ep;
    logic [7:0] ec;
    ep = {mo[5:1], mo[6] ? mi[3] : mo[0]};
    ec = {mo[5:1], mo[6] ? mi[2] : mo[0], mi[1:0]};
    chk(tag, "prg_bank", {2'b00, prg_bank}, {2'b00, ep});
    chk(tag, "chr_bank", chr_bank, ec);
    chk(tag, "mirror_h", {7'd0, mirror_h}, {7'd0, mo[7]});
  endtask

  // reference update taken from the requirements
  task automatic model(input logic [15:0] a, input logic [7:0] d);
    bit low;
    low = (a >= 16'h4100) && (a <= 16'h7FFF);
    if (a[15]) begin
      if (mo[5]) mi = {4'b0000, d[0], d[6:4]};
    end else if (low) begin
      if (proto_mode) begin
        if (a[9]) mo = d;
        else if (a[8]) mi = d;
      end else if (a[8]) begin
        if (a[7]) mo = d;
        else if (!mo[5]) mi = d;
      end
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model(a, d);
  endtask

  function automatic string region(input logic [15:0] a);
    if (a < 16'h4100) return "R9";
    if (a[15]) return "R4";
    if (proto_mode) return "R5";
    return (a[8] && a[7]) ? "R2" : "R3";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // outer sweep, normal decode
    for (int o = 0; o < 256; o++) begin
      wr(16'h4180 | 16'(o & 8'h0F), 8'(o));
      check_all("R2");
      check_all("R8");
      wr(16'h4100 | 16'(o & 8'h7F), 8'(o) ^ 8'h5A);
      check_all("R3");
      check_all("R6");
      wr(16'h8000 | 16'(o << 6), ~8'(o));
      check_all("R4");
      check_all("R7");
    end

    // address sweep, normal then prototype decode
    for (int pm = 0; pm < 2; pm++) begin
      proto_mode = pm[0];
      wr(16'h4180, 8'h40);
      if (pm == 1) wr(16'h4200, 8'h40);
      wr(16'h4100, 8'h00);
      for (int p = 0; p < 256; p++) begin
        for (int k = 0; k < 4; k++) begin
          logic [7:0] off;
          logic [15:0] a;
          off = (k == 0) ? 8'h00 : (k == 1) ? 8'h80 : (k == 2) ? 8'h7F : 8'hFF;
          a = {8'(p), off};
          wr(a, 8'(p) ^ 8'(k * 37) ^ 8'h11);
          check_all(region(a));
        end
      end
    end
    proto_mode = 1'b0;

    // bus cycles without the strobe
    wr(16'h4180, 8'h7F);
    wr(16'h4100, 8'h3C);
    @(negedge clk);
    cpu_addr = 16'h4180; cpu_data = 8'h80;
    @(negedge clk);
    cpu_addr = 16'h8000; cpu_data = 8'hFF;
    @(negedge clk);
    check_all("R9");

    // reset from a non-zero state
    wr(16'h4180, 8'hC3);
    rst_n = 1'b0;
    @(negedge clk);
    mo = '0; mi = '0;
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule